// File: doc/BRIEF.md
# UART FIFO Control with Receive Character Timeout

This block holds the transmit and receive byte queues of a 16550-class serial port, together with the write-only control byte that manages them and the receive idle-timeout detector. The host bus writes the control byte. The receive serial engine pushes received bytes, each carrying three error flags. The transmit serial engine pops bytes for sending. The host pushes transmit bytes and pops received ones. The serial shift registers are outside this block. Emptying a queue therefore never touches a character that is already being shifted.

Bit 0 of the control byte selects queued mode. With it set, each queue holds up to 16 entries. With it clear, each queue acts as a one-entry holding register. The other control bits are obeyed only in a write that also sets bit 0: bit 1 empties the receive queue, bit 2 empties the transmit queue, and bits 7:6 pick the receive fill threshold. The block reports both fill levels, a threshold-reached flag, a receive timeout flag and a one-cycle receive overrun pulse. The timeout is measured in character times, counted from an external strobe that pulses once per character time.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both levels are 0, queued mode is off, and `rxTrigHit`, `rxTimeout` and `rxOverrun` are all 0.
- R2: After a write with bit 0 = 1, each queue accepts up to 16 entries and returns them in push order. Pop data is valid whenever the level is non-zero, and it shows the oldest entry before the pop strobe.
- R3: A control write with bit 0 = 0 leaves queued mode and empties both queues, whatever the other bits hold. Any write that changes bit 0 also empties both queues. While queued mode is off, each queue holds at most one entry.
- R4: A write with bits 0 and 1 set empties the receive queue on the clock edge of the write. The transmit queue is left unchanged.
- R5: A write with bits 0 and 2 set empties the transmit queue on the clock edge of the write. The receive queue is left unchanged.
- R6: The emptying bits act only in the write that carries them. A later write with bit 0 = 1 and bits 2:1 = 0, made while already in queued mode, changes neither level.
- R7: Bits 7:6 of an enabling write set the receive threshold: 00 → 1, 01 → 4, 10 → 8, 11 → 14 entries. `rxTrigHit` is 1 exactly while the receive level is at or above the threshold, and it falls as soon as the level drops below it. With queued mode off, the threshold is 1.
- R8: In queued mode with a non-empty receive queue, `rxTimeout` rises in the cycle after the 4th `charTick` pulse that arrives with no receive push or pop. Any receive push or pop restarts the count.
- R9: `rxTimeout` returns to 0 after a receive pop, after the receive queue is emptied, and after queued mode is left.
- R10: A push to a full queue is dropped. For the receive queue, `rxOverrun` is 1 for exactly the one cycle after the dropped push.
- R11: A pop on an empty queue leaves its level at 0 and has no effect on later data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Control byte write strobe |
| cfgData | input | 8 | Control byte |
| charTick | input | 1 | One pulse per character time |
| txPush | input | 1 | Host pushes a transmit byte |
| txPushData | input | 8 | Transmit byte |
| txPop | input | 1 | Transmit engine takes a byte |
| txPopData | output | 8 | Oldest transmit byte |
| txLevel | output | 5 | Transmit fill level |
| rxPush | input | 1 | Receive engine pushes a byte |
| rxPushData | input | 11 | {error flags[2:0], byte[7:0]} |
| rxPop | input | 1 | Host takes a received byte |
| rxPopData | output | 11 | Oldest received entry |
| rxLevel | output | 5 | Receive fill level |
| fifoOn | output | 1 | Queued mode active |
| rxTrigHit | output | 1 | Receive level at or above threshold |
| rxTimeout | output | 1 | Receive character timeout |
| rxOverrun | output | 1 | Receive push was dropped |

## Verification
A pointer or level register that goes wrong appears one cycle later as a level that differs from the bench model. It also appears as wrong data at the next pop, because the read port shows the head entry before the pop strobe. A miscount in the idle counter moves the rise of `rxTimeout` by one character tick, so a check placed on exactly the third and fourth ticks catches it. A wrongly held threshold selection or mode bit shows as `rxTrigHit` toggling at the wrong level in the very cycle of the push.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

  // Strobes from the control decode to the queue datapath
  typedef struct packed {
    logic fifoEn;   // queued mode (registered)
    logic flushRx;  // empty receive queue this edge
    logic flushTx;  // empty transmit queue this edge
  } ufcCtl_t;

  // Receive threshold for each value of the two-bit selection field
  function automatic int trigThreshold(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       capOne,
  input  logic                       push,
  input  logic [WIDTH-1:0]           pushData,
  input  logic                       pop,
  output logic [WIDTH-1:0]           popData,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rdPtr, wrPtr;
  logic             pushOk, popOk;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level == '0);
  assign full    = capOne ? !empty : (level == LW'(DEPTH));
  assign popOk   = pop && !empty;
  assign pushOk  = push && (!full || popOk);
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else if (flush) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      overrun <= push && !pushOk;
    end
  end

  // Storage has no reset; only pointers and level define contents
  always_ff @(posedge clk) begin
    if (pushOk && !flush) mem[wrPtr] <= pushData;
  end

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LW'(DEPTH));
  a_r3_single_entry: assert property (@(posedge clk) disable iff (!rstN)
    capOne && !flush |=> level <= LW'(1));
  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> level == '0);
  a_r10_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(push && full && !pop));
  a_r11_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    pop && empty && !push |=> level == '0);
endmodule

// File: rtl/ufc_datapath.sv
module ufc_datapath
  import ufc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ufcCtl_t                     ctl,
  input  logic                        txPush,
  input  logic [DATA_W-1:0]           txPushData,
  input  logic                        txPop,
  output logic [DATA_W-1:0]           txPopData,
  output logic [$clog2(DEPTH+1)-1:0]  txLevel,
  input  logic                        rxPush,
  input  logic [DATA_W+ERR_W-1:0]     rxPushData,
  input  logic                        rxPop,
  output logic [DATA_W+ERR_W-1:0]     rxPopData,
  output logic [$clog2(DEPTH+1)-1:0]  rxLevel,
  output logic                        rxOverrun
);
  logic txFull, txEmpty, txOverrun, rxFull, rxEmpty;
  logic unusedFlags;

  // Transmit full/empty/overrun are not needed at the block edge
  assign unusedFlags = txFull ^ txEmpty ^ txOverrun ^ rxFull ^ rxEmpty;

  ufc_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) txQueue (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (ctl.flushTx),
    .capOne   (!ctl.fifoEn),
    .push     (txPush),
    .pushData (txPushData),
    .pop      (txPop),
    .popData  (txPopData),
    .level    (txLevel),
    .full     (txFull),
    .empty    (txEmpty),
    .overrun  (txOverrun)
  );

  ufc_fifo #(.WIDTH(DATA_W + ERR_W), .DEPTH(DEPTH)) rxQueue (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (ctl.flushRx),
    .capOne   (!ctl.fifoEn),
    .push     (rxPush),
    .pushData (rxPushData),
    .pop      (rxPop),
    .popData  (rxPopData),
    .level    (rxLevel),
    .full     (rxFull),
    .empty    (rxEmpty),
    .overrun  (rxOverrun)
  );
endmodule

// File: rtl/ufc_control.sv
module ufc_control
  import ufc_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWr,
  input  logic [7:0]                  cfgData,
  input  logic                        charTick,
  input  logic                        rxPush,
  input  logic                        rxPop,
  input  logic [$clog2(DEPTH+1)-1:0]  rxLevel,
  output ufcCtl_t                     ctl,
  output logic                        rxTrigHit,
  output logic                        rxTimeout
);
  localparam int BIT_EN    = 0;
  localparam int BIT_RXCLR = 1;
  localparam int BIT_TXCLR = 2;
  localparam int TRIG_LSB  = 6;
  localparam int CW        = $clog2(TO_CHARS + 1);

  logic          enReg;
  logic [1:0]    trigSel;
  logic [CW-1:0] idleCnt;
  logic          idleRestart;
  logic          flagClear;
  logic          enWrite;
  logic          unusedCfg;

  assign unusedCfg = ^cfgData[5:3];
  assign enWrite   = cfgWr && cfgData[BIT_EN];

  // Leaving queued mode, or entering it, empties both queues
  always_comb begin
    ctl.fifoEn  = enReg;
    ctl.flushRx = cfgWr && (!cfgData[BIT_EN] || !enReg || cfgData[BIT_RXCLR]);
    ctl.flushTx = cfgWr && (!cfgData[BIT_EN] || !enReg || cfgData[BIT_TXCLR]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      trigSel <= 2'd0;
    end else if (cfgWr) begin
      enReg <= cfgData[BIT_EN];
      if (enWrite) trigSel <= cfgData[TRIG_LSB +: 2];
    end
  end

  assign rxTrigHit = enReg ? (int'(rxLevel) >= trigThreshold(trigSel))
                           : (rxLevel != '0);

  // Idle character-time counter
  assign idleRestart = rxPush || rxPop || ctl.flushRx || !enReg || (rxLevel == '0);
  assign flagClear   = rxPop || ctl.flushRx || !enReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt   <= '0;
      rxTimeout <= 1'b0;
    end else begin
      if (idleRestart)
        idleCnt <= '0;
      else if (charTick && idleCnt != CW'(TO_CHARS))
        idleCnt <= idleCnt + 1'b1;

      if (flagClear)
        rxTimeout <= 1'b0;
      else if (!idleRestart && charTick && idleCnt == CW'(TO_CHARS - 1))
        rxTimeout <= 1'b1;
    end
  end

  a_r3_disable_write: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr && !cfgData[BIT_EN] |=> !ctl.fifoEn);
  a_r7_sel_kept: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr && !cfgData[BIT_EN] |=> $stable(trigSel));
  a_r8_rise_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxTimeout) |-> $past(charTick && !rxPush && !rxPop));
  a_r9_timeout_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    rxTimeout |-> rxLevel != '0);
  a_r9_pop_clears: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |=> !rxTimeout);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import ufc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ERR_W    = 3,
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWr,
  input  logic [7:0]                  cfgData,
  input  logic                        charTick,
  input  logic                        txPush,
  input  logic [DATA_W-1:0]           txPushData,
  input  logic                        txPop,
  output logic [DATA_W-1:0]           txPopData,
  output logic [$clog2(DEPTH+1)-1:0]  txLevel,
  input  logic                        rxPush,
  input  logic [DATA_W+ERR_W-1:0]     rxPushData,
  input  logic                        rxPop,
  output logic [DATA_W+ERR_W-1:0]     rxPopData,
  output logic [$clog2(DEPTH+1)-1:0]  rxLevel,
  output logic                        fifoOn,
  output logic                        rxTrigHit,
  output logic                        rxTimeout,
  output logic                        rxOverrun
);
  ufcCtl_t ctl;

  ufc_control #(.DEPTH(DEPTH), .TO_CHARS(TO_CHARS)) control (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWr     (cfgWr),
    .cfgData   (cfgData),
    .charTick  (charTick),
    .rxPush    (rxPush),
    .rxPop     (rxPop),
    .rxLevel   (rxLevel),
    .ctl       (ctl),
    .rxTrigHit (rxTrigHit),
    .rxTimeout (rxTimeout)
  );

  ufc_datapath #(.DATA_W(DATA_W), .ERR_W(ERR_W), .DEPTH(DEPTH)) datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .txPush     (txPush),
    .txPushData (txPushData),
    .txPop      (txPop),
    .txPopData  (txPopData),
    .txLevel    (txLevel),
    .rxPush     (rxPush),
    .rxPushData (rxPushData),
    .rxPop      (rxPop),
    .rxPopData  (rxPopData),
    .rxLevel    (rxLevel),
    .rxOverrun  (rxOverrun)
  );

  assign fifoOn = ctl.fifoEn;
endmodule

// File: tb/tb_uart_fifo_ctrl.sv
module tb_uart_fifo_ctrl;
  localparam int DW = 8;
  localparam int EW = 3;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, cfgWr = 1'b0, charTick = 1'b0;
  logic [7:0] cfgData = '0;
  logic txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic [DW-1:0] txPushData = '0, txPopData;
  logic [DW+EW-1:0] rxPushData = '0, rxPopData;
  logic [LW-1:0] txLevel, rxLevel;
  logic fifoOn, rxTrigHit, rxTimeout, rxOverrun;

  uart_fifo_ctrl dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData), .charTick(charTick),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .txLevel(txLevel), .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop),
    .rxPopData(rxPopData), .rxLevel(rxLevel), .fifoOn(fifoOn), .rxTrigHit(rxTrigHit),
    .rxTimeout(rxTimeout), .rxOverrun(rxOverrun)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [DW-1:0] txQ[$];
  logic [DW+EW-1:0] rxQ[$];
  bit modeOn = 1'b0;
  int thrModel = 1;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cap();
    return modeOn ? DEPTH : 1;
  endfunction

  function automatic int expTrig();
    return modeOn ? int'(rxQ.size() >= thrModel) : int'(rxQ.size() >= 1);
  endfunction

  task automatic levels(input string req);
    chk({req, " rx level"}, rxLevel, rxQ.size());
    chk({req, " tx level"}, txLevel, txQ.size());
  endtask

  task automatic cfg(input logic [7:0] b);
    cfgWr = 1'b1; cfgData = b;
    tick();
    cfgWr = 1'b0;
    if (!b[0] || !modeOn) begin
      rxQ.delete(); txQ.delete();
    end else begin
      if (b[1]) rxQ.delete();
      if (b[2]) txQ.delete();
    end
    modeOn = b[0];
    if (b[0]) begin
      case (b[7:6])
        2'd0: thrModel = 1;
        2'd1: thrModel = 4;
        2'd2: thrModel = 8;
        default: thrModel = 14;
      endcase
    end
  endtask

  task automatic pushRx(input logic [DW+EW-1:0] d, output bit dropped);
    dropped = (rxQ.size() >= cap());
    rxPush = 1'b1; rxPushData = d;
    tick();
    rxPush = 1'b0;
    if (!dropped) rxQ.push_back(d);
  endtask

  task automatic pushTx(input logic [DW-1:0] d);
    txPush = 1'b1; txPushData = d;
    tick();
    txPush = 1'b0;
    if (txQ.size() < cap()) txQ.push_back(d);
  endtask

  // Monitor side of the scoreboard: compare the head before taking it
  task automatic popRx(input string req);
    if (rxQ.size() > 0) chk({req, " rx data"}, rxPopData, rxQ[0]);
    rxPop = 1'b1;
    tick();
    rxPop = 1'b0;
    if (rxQ.size() > 0) void'(rxQ.pop_front());
  endtask

  task automatic popTx(input string req);
    if (txQ.size() > 0) chk({req, " tx data"}, txPopData, txQ[0]);
    txPop = 1'b1;
    tick();
    txPop = 1'b0;
    if (txQ.size() > 0) void'(txQ.pop_front());
  endtask

  task automatic charPulse(input int n);
    for (int i = 0; i < n; i++) begin
      charTick = 1'b1;
      tick();
      charTick = 1'b0;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    bit dr;
    @(negedge clk);
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1
    levels("R1");
    chk("R1 fifoOn", fifoOn, 0);
    chk("R1 trig", rxTrigHit, 0);
    chk("R1 timeout", rxTimeout, 0);
    chk("R1 overrun", rxOverrun, 0);

    // R3/R10: holding-register mode, one entry
    pushRx(11'h5A1, dr);
    chk("R3 hold level", rxLevel, 1);
    chk("R7 trig non-queued", rxTrigHit, 1);
    pushRx(11'h0B2, dr);
    chk("R10 overrun pulse", rxOverrun, 1);
    chk("R3 hold capped", rxLevel, 1);
    tick();
    chk("R10 overrun one cycle", rxOverrun, 0);
    popRx("R10 kept first");
    levels("R3");

    // R11: pop on empty
    popTx("R11");
    chk("R11 tx level", txLevel, 0);

    // R2: queued mode, full depth, order
    cfg(8'h41);
    chk("R2 fifoOn", fifoOn, 1);
    for (int i = 0; i < DEPTH + 1; i++) pushTx(8'(8'h30 + i * 7));
    chk("R10 tx full dropped", txLevel, DEPTH);
    for (int i = 0; i < DEPTH; i++) popTx("R2");
    levels("R2 drained");

    // R7: threshold 4
    for (int i = 0; i < 3; i++) pushRx(11'(11'h100 + i), dr);
    chk("R7 below 4", rxTrigHit, 0);
    pushRx(11'h7FF, dr);
    chk("R7 at 4", rxTrigHit, 1);
    popRx("R7");
    chk("R7 drop below", rxTrigHit, expTrig());

    // R6: enable write without emptying bits keeps contents
    pushTx(8'hA5); pushTx(8'h3C);
    cfg(8'hC1);
    levels("R6");
    chk("R7 thr14 at 3", rxTrigHit, 0);
    for (int i = 0; i < 10; i++) pushRx(11'(11'h200 + i), dr);
    chk("R7 thr14 at 13", rxTrigHit, 0);
    pushRx(11'h2AA, dr);
    chk("R7 thr14 at 14", rxTrigHit, 1);

    // R4: receive only
    cfg(8'h03);
    levels("R4");
    chk("R7 thr1 empty", rxTrigHit, 0);
    pushRx(11'h011, dr);
    chk("R7 thr1 one", rxTrigHit, 1);
    // R5: transmit only
    cfg(8'h05);
    levels("R5");
    popTx("R11 after flush");
    chk("R11 tx still empty", txLevel, 0);

    // R8/R9: timeout
    charPulse(3);
    chk("R8 three ticks", rxTimeout, 0);
    charPulse(1);
    chk("R8 fourth tick", rxTimeout, 1);
    popRx("R9");
    chk("R9 pop clears", rxTimeout, 0);
    pushRx(11'h044, dr);
    charPulse(2);
    pushRx(11'h055, dr);
    charPulse(3);
    chk("R8 push restarts", rxTimeout, 0);
    charPulse(1);
    chk("R8 after restart", rxTimeout, 1);
    popRx("R9");
    chk("R9 pop clears 2", rxTimeout, 0);
    charPulse(3);
    chk("R8 pop restarts", rxTimeout, 0);
    charPulse(1);
    chk("R8 after pop", rxTimeout, 1);
    cfg(8'h03);
    chk("R9 flush clears", rxTimeout, 0);
    pushRx(11'h066, dr);
    charPulse(4);
    chk("R8 again", rxTimeout, 1);

    // R3: disable write with other bits set
    pushTx(8'h77);
    cfg(8'hC6);
    chk("R3 fifoOn off", fifoOn, 0);
    chk("R9 disable clears", rxTimeout, 0);
    levels("R3 disable");
    pushRx(11'h123, dr);
    pushRx(11'h321, dr);
    chk("R3 single entry", rxLevel, 1);
    popRx("R3");
    // enabling again empties (mode change)
    pushTx(8'h99);
    cfg(8'h01);
    levels("R3 enable change");

    tick();
    finish();
  end
endmodule